// File: doc/BRIEF.md
# Branch Prediction Front-End Unit

This unit supplies the next fetch address for a single-issue, in-order instruction fetch front end. Each cycle the fetch PC indexes a direct-mapped branch target table. Each entry holds a valid bit, an address tag, a target and a 2-bit saturating direction counter. On a hit whose counter predicts taken, the stored target becomes the next fetch PC in the same cycle, so no fetch bubble is added. Otherwise fetch continues at PC+4. When an execute-stage branch resolves, it trains the table. A taken branch that missed the table is allocated with a weakly-taken counter. A branch that hit the table has its counter moved up or down.

At decode, a branch that the table did not predict is handled by a static rule and a small return stack. A conditional direct branch with a negative displacement is predicted taken. One with a positive displacement is predicted not taken. Unconditional direct branches and calls are always redirected to their target. Calls push PC+4 on a three-entry circular return stack. An unconditional return pops the stack and redirects to the popped address. Conditional returns never use the stack.

A mispredict reported by execute starts a penalty state machine with the states PS_IDLE, PS_FLUSH and PS_REFILL. On the mispredict the machine moves from PS_IDLE, or from any other state, to PS_FLUSH. It moves from PS_FLUSH to PS_REFILL after one cycle. It moves from PS_REFILL back to PS_IDLE once its refill counter reaches zero. Together the states give a one-cycle flush pulse, a registered correct-path address and a busy window of six cycles in total.

Top module: `bpu_top`

## Requirements
- R1: After reset the table holds no valid entries, so `btac_hit` is 0 and `next_pc` equals `fetch_pc`+4. The return stack is empty, and `flush` and `busy` are 0.
- R2: After a taken branch at PC p with target t resolves (`ex_valid`=1, `ex_taken`=1) and misses the table, a lookup of p in any later cycle gives `btac_hit`=1, `pred_taken`=1 and `next_pc`=t in the same cycle as the lookup.
- R3: A not-taken resolution of a branch that misses the table allocates nothing: a later lookup of that PC gives `btac_hit`=0 and `next_pc`=PC+4.
- R4: A resolution that hits the table raises the 2-bit counter when the branch is taken and lowers it when it is not, saturating at 0 and 3. A new entry starts at 2. The prediction is taken when counter bit 1 is set. A not-taken prediction on a hit gives `next_pc`=PC+4.
- R5: The table index is PC bits [8:2] and the tag is PC bits [31:9], with bits [1:0] ignored. Two PCs with the same index and different tags displace each other.
- R6: With `dec_valid`=1 and `dec_btac_hit`=0, `redir_valid`=1 and `redir_pc`=`dec_pc`+`dec_disp` are produced in the same cycle in two cases. The first is a direct branch that is unconditional or a call. The second is a conditional direct branch whose displacement has bit 31 set (backward). A conditional direct branch with bit 31 clear (forward) gives `redir_valid`=0.
- R7: When `dec_btac_hit`=1, decode never redirects.
- R8: A decoded call pushes `dec_pc`+4. A decoded unconditional return with `dec_btac_hit`=0 and a non-empty stack redirects to the most recently pushed address and removes it (last-in, first-out).
- R9: A conditional return (`dec_is_ret`=1 with `dec_is_cond`=1) gives no redirect and leaves the stack unchanged.
- R10: A fourth push without a pop overwrites the oldest entry, so only the three newest addresses can be popped. A return on an empty stack gives `redir_valid`=0, and fetch stays sequential.
- R11: `ex_mispredict` in cycle n gives `flush`=1 in cycle n+1 only. In that cycle `fix_pc` is `ex_target` if `ex_taken` was 1 and `ex_pc`+4 otherwise. `busy` is 1 for cycles n+1 to n+6 and 0 in cycle n+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | 32 | Current fetch address |
| next_pc | output | 32 | Predicted next fetch address |
| btac_hit | output | 1 | Fetch PC hit in target table |
| pred_taken | output | 1 | Hit with taken prediction |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_pc | input | 32 | Address of decoded instruction |
| dec_disp | input | 32 | Signed branch displacement |
| dec_is_br | input | 1 | Direct branch |
| dec_is_cond | input | 1 | Branch or return is conditional |
| dec_is_call | input | 1 | Procedure call |
| dec_is_ret | input | 1 | Procedure return |
| dec_btac_hit | input | 1 | Fetch-stage table hit carried to decode |
| redir_valid | output | 1 | Decode redirect request |
| redir_pc | output | 32 | Decode redirect address |
| ex_valid | input | 1 | A branch resolves this cycle |
| ex_pc | input | 32 | Resolved branch address |
| ex_taken | input | 1 | Resolved direction |
| ex_target | input | 32 | Resolved target |
| ex_mispredict | input | 1 | Resolved prediction was wrong |
| flush | output | 1 | One-cycle pipeline flush |
| busy | output | 1 | Mispredict penalty window active |
| fix_pc | output | 32 | Correct-path restart address |

## Verification
The target table is tested with one branch trained through a sequence of taken and not-taken outcomes. The sequence separates correct saturation at both ends from wrap-around and from a counter that never moves. A second PC with the same index but a different tag, and a lookup with the low two bits changed, show whether the tag uses the right bits. Decode patterns cover backward, forward and unconditional branches, each with and without a table hit, which separates the static rule from the hit override. Call/return sequences check last-in, first-out order, overflow after four pushes, an empty pop and a conditional return. Taken and not-taken mispredicts check the flush timing, the six-cycle window and the restart address.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_FLUSH  = 2'd1,
        PS_REFILL = 2'd2
    } pen_state_t;
endpackage

// File: rtl/bpu_btac.sv
module bpu_btac #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 7,
    parameter int CTR_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] look_pc,
    output logic            look_hit,
    output logic            look_taken,
    output logic [PC_W-1:0] look_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = PC_W - IDX_W - 2;
    localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_WEAK = CTR_W'(1) << (CTR_W - 1);

    logic [ENTRIES-1:0] vld;
    logic [TAG_W-1:0]   tag_mem [ENTRIES];
    logic [PC_W-1:0]    tgt_mem [ENTRIES];
    logic [CTR_W-1:0]   ctr_mem [ENTRIES];

    logic [IDX_W-1:0] l_idx, u_idx;
    logic [TAG_W-1:0] l_tag, u_tag;
    logic             u_hit;
    logic [CTR_W-1:0] u_ctr_next;
    logic             unused_low;

    assign l_idx = look_pc[IDX_W+1:2];
    assign l_tag = look_pc[PC_W-1:IDX_W+2];
    assign u_idx = upd_pc[IDX_W+1:2];
    assign u_tag = upd_pc[PC_W-1:IDX_W+2];
    assign unused_low = ^{look_pc[1:0], upd_pc[1:0]};

    assign look_hit    = vld[l_idx] && (tag_mem[l_idx] == l_tag);
    assign look_taken  = look_hit && ctr_mem[l_idx][CTR_W-1];
    assign look_target = tgt_mem[l_idx];

    assign u_hit = vld[u_idx] && (tag_mem[u_idx] == u_tag);

    always_comb begin
        u_ctr_next = ctr_mem[u_idx];
        if (upd_taken) begin
            if (ctr_mem[u_idx] != CTR_MAX) u_ctr_next = ctr_mem[u_idx] + CTR_W'(1);
        end else begin
            if (ctr_mem[u_idx] != '0) u_ctr_next = ctr_mem[u_idx] - CTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (upd_valid && !u_hit && upd_taken) begin
            vld[u_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_valid) begin
            if (u_hit) begin
                ctr_mem[u_idx] <= u_ctr_next;
                if (upd_taken) tgt_mem[u_idx] <= upd_target;
            end else if (upd_taken) begin
                tag_mem[u_idx] <= u_tag;
                tgt_mem[u_idx] <= upd_target;
                ctr_mem[u_idx] <= CTR_WEAK;
            end
        end
    end
endmodule

// File: rtl/bpu_ras.sv
module bpu_ras #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] push_addr,
    input  logic            pop,
    output logic            top_valid,
    output logic [PC_W-1:0] top_addr
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [PC_W-1:0]  stk [DEPTH];
    logic [PTR_W-1:0] wptr, top_idx;
    logic [CNT_W-1:0] cnt;

    assign top_idx   = (wptr == '0) ? LAST : wptr - PTR_W'(1);
    assign top_valid = (cnt != '0);
    assign top_addr  = stk[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            cnt  <= '0;
        end else if (push) begin
            wptr <= (wptr == LAST) ? '0 : wptr + PTR_W'(1);
            if (cnt != FULL) cnt <= cnt + CNT_W'(1);
        end else if (pop && top_valid) begin
            wptr <= top_idx;
            cnt  <= cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) stk[wptr] <= push_addr;
    end
endmodule

// File: rtl/bpu_penalty_fsm.sv
module bpu_penalty_fsm
    import bpu_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PENALTY = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mispredict,
    input  logic [PC_W-1:0] good_pc,
    output logic            flush,
    output logic            busy,
    output logic [PC_W-1:0] fix_pc
);
    localparam int CW = $clog2(PENALTY + 1);
    localparam logic [CW-1:0] REFILL_LOAD = CW'(PENALTY - 2);

    pen_state_t state, state_nx;
    logic [CW-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE:   state_nx = PS_IDLE;
            PS_FLUSH:  state_nx = PS_REFILL;
            PS_REFILL: state_nx = (cnt == '0) ? PS_IDLE : PS_REFILL;
            default:   state_nx = PS_IDLE;
        endcase
        if (mispredict) state_nx = PS_FLUSH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PS_IDLE;
            cnt    <= '0;
            fix_pc <= '0;
        end else begin
            state <= state_nx;
            if (mispredict) fix_pc <= good_pc;
            if (state == PS_FLUSH) cnt <= REFILL_LOAD;
            else if (state == PS_REFILL && cnt != '0) cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        flush = 1'b0;
        busy  = 1'b0;
        unique case (state)
            PS_IDLE:   ;
            PS_FLUSH:  begin flush = 1'b1; busy = 1'b1; end
            PS_REFILL: busy = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/bpu_top.sv
module bpu_top #(
    parameter int PC_W      = 32,
    parameter int IDX_W     = 7,
    parameter int CTR_W     = 2,
    parameter int RAS_DEPTH = 3,
    parameter int PENALTY   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            btac_hit,
    output logic            pred_taken,
    input  logic            dec_valid,
    input  logic [PC_W-1:0] dec_pc,
    input  logic [PC_W-1:0] dec_disp,
    input  logic            dec_is_br,
    input  logic            dec_is_cond,
    input  logic            dec_is_call,
    input  logic            dec_is_ret,
    input  logic            dec_btac_hit,
    output logic            redir_valid,
    output logic [PC_W-1:0] redir_pc,
    input  logic            ex_valid,
    input  logic [PC_W-1:0] ex_pc,
    input  logic            ex_taken,
    input  logic [PC_W-1:0] ex_target,
    input  logic            ex_mispredict,
    output logic            flush,
    output logic            busy,
    output logic [PC_W-1:0] fix_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [PC_W-1:0] look_target;
    logic            ras_push, ras_pop, ras_valid;
    logic [PC_W-1:0] ras_addr, good_pc, br_target;
    logic            uncond_ret;

    bpu_btac #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) btac_i (
        .clk(clk), .rst_n(rst_n),
        .look_pc(fetch_pc), .look_hit(btac_hit), .look_taken(pred_taken),
        .look_target(look_target),
        .upd_valid(ex_valid), .upd_pc(ex_pc), .upd_taken(ex_taken),
        .upd_target(ex_target)
    );

    assign next_pc = pred_taken ? look_target : fetch_pc + STEP;

    assign uncond_ret = dec_valid && dec_is_ret && !dec_is_cond;
    assign ras_push   = dec_valid && dec_is_call;
    assign ras_pop    = uncond_ret;
    assign br_target  = dec_pc + dec_disp;

    bpu_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) ras_i (
        .clk(clk), .rst_n(rst_n),
        .push(ras_push), .push_addr(dec_pc + STEP),
        .pop(ras_pop), .top_valid(ras_valid), .top_addr(ras_addr)
    );

    always_comb begin
        redir_valid = 1'b0;
        redir_pc    = br_target;
        if (dec_valid && !dec_btac_hit) begin
            if (dec_is_ret) begin
                if (!dec_is_cond && ras_valid) begin
                    redir_valid = 1'b1;
                    redir_pc    = ras_addr;
                end
            end else if (dec_is_call || (dec_is_br && !dec_is_cond)) begin
                redir_valid = 1'b1;
            end else if (dec_is_br && dec_disp[PC_W-1]) begin
                redir_valid = 1'b1;
            end
        end
    end

    assign good_pc = ex_taken ? ex_target : ex_pc + STEP;

    bpu_penalty_fsm #(.PC_W(PC_W), .PENALTY(PENALTY)) pen_i (
        .clk(clk), .rst_n(rst_n),
        .mispredict(ex_mispredict), .good_pc(good_pc),
        .flush(flush), .busy(busy), .fix_pc(fix_pc)
    );
endmodule

// File: rtl/bpu_chk.sv
module bpu_chk #(
    parameter int PC_W    = 32,
    parameter int PENALTY = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_valid,
    input logic [PC_W-1:0] dec_pc,
    input logic [PC_W-1:0] dec_disp,
    input logic            dec_is_br,
    input logic            dec_is_cond,
    input logic            dec_is_call,
    input logic            dec_is_ret,
    input logic            dec_btac_hit,
    input logic            redir_valid,
    input logic [PC_W-1:0] redir_pc,
    input logic            ex_mispredict,
    input logic            flush,
    input logic            busy
);
    localparam int LW = $clog2(PENALTY + 1) + 1;
    logic [LW-1:0] run_len;
    logic static_case;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_len <= '0;
        else if (busy) run_len <= flush ? LW'(1) : run_len + LW'(1);
        else run_len <= '0;
    end

    assign static_case = dec_valid && !dec_btac_hit && dec_is_br && dec_is_cond
                         && !dec_is_ret && !dec_is_call;

    assert_flush_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ex_mispredict |=> flush);
    assert_flush_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(ex_mispredict));
    assert_busy_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flush) |-> (run_len < LW'(PENALTY)));
    assert_busy_length_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == LW'(PENALTY)));
    assert_hit_no_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_btac_hit) |-> !redir_valid);
    assert_cond_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_ret && dec_is_cond) |-> !redir_valid);
    assert_backward_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (static_case && dec_disp[PC_W-1]) |-> (redir_valid && redir_pc == dec_pc + dec_disp));
    assert_forward_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (static_case && !dec_disp[PC_W-1]) |-> !redir_valid);
endmodule

bind bpu_top bpu_chk #(.PC_W(PC_W), .PENALTY(PENALTY)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_disp(dec_disp),
    .dec_is_br(dec_is_br), .dec_is_cond(dec_is_cond), .dec_is_call(dec_is_call),
    .dec_is_ret(dec_is_ret), .dec_btac_hit(dec_btac_hit),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .ex_mispredict(ex_mispredict), .flush(flush), .busy(busy)
);

// File: tb/bpu_top_tb_top.sv
`timescale 1ns/1ps
module bpu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0, next_pc;
    logic        btac_hit, pred_taken;
    logic        dec_valid = 0, dec_is_br = 0, dec_is_cond = 0, dec_is_call = 0;
    logic        dec_is_ret = 0, dec_btac_hit = 0;
    logic [31:0] dec_pc = '0, dec_disp = '0;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic        ex_valid = 0, ex_taken = 0, ex_mispredict = 0;
    logic [31:0] ex_pc = '0, ex_target = '0;
    logic        flush, busy;
    logic [31:0] fix_pc;

    always #2.5 clk = ~clk;

    bpu_top dut_i (.*);

    typedef enum int {K_NEXT, K_HIT, K_TAKEN, K_RV, K_RPC, K_FLUSH, K_BUSY, K_FIX} kind_t;
    typedef struct {
        kind_t       kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    function automatic logic [31:0] observe(kind_t k);
        case (k)
            K_NEXT:  return next_pc;
            K_HIT:   return {31'd0, btac_hit};
            K_TAKEN: return {31'd0, pred_taken};
            K_RV:    return {31'd0, redir_valid};
            K_RPC:   return redir_pc;
            K_FLUSH: return {31'd0, flush};
            K_BUSY:  return {31'd0, busy};
            default: return fix_pc;
        endcase
    endfunction

    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = observe(it.kind);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s: actual %h expected %h", it.req, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(kind_t k, logic [31:0] e, string req);
        item_t it;
        it.kind = k; it.exp = e; it.req = req;
        q.push_back(it);
    endtask

    task automatic lookup(logic [31:0] pc, bit hit, logic [31:0] nxt, string req);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        expect_v(K_HIT, {31'd0, hit}, req);
        expect_v(K_NEXT, nxt, req);
        ->sample_ev;
    endtask

    task automatic resolve(logic [31:0] pc, bit taken, logic [31:0] tgt);
        @(negedge clk);
        ex_valid = 1; ex_pc = pc; ex_taken = taken; ex_target = tgt;
        @(negedge clk);
        ex_valid = 0;
    endtask

    task automatic decode(logic [31:0] pc, logic [31:0] disp, bit br, bit cond, bit call,
                          bit ret, bit hit, bit rv, logic [31:0] rpc, string req);
        @(negedge clk);
        dec_valid = 1; dec_pc = pc; dec_disp = disp; dec_is_br = br; dec_is_cond = cond;
        dec_is_call = call; dec_is_ret = ret; dec_btac_hit = hit;
        #1;
        expect_v(K_RV, {31'd0, rv}, req);
        if (rv) expect_v(K_RPC, rpc, req);
        ->sample_ev;
        @(negedge clk);
        dec_valid = 0; dec_is_br = 0; dec_is_cond = 0; dec_is_call = 0; dec_is_ret = 0;
        dec_btac_hit = 0;
    endtask

    task automatic mispredict(logic [31:0] pc, bit taken, logic [31:0] tgt, logic [31:0] fix);
        @(negedge clk);
        ex_mispredict = 1; ex_pc = pc; ex_taken = taken; ex_target = tgt;
        @(posedge clk); #1;
        expect_v(K_FLUSH, 32'd1, "R11");
        expect_v(K_BUSY, 32'd1, "R11");
        expect_v(K_FIX, fix, "R11");
        ->sample_ev;
        @(negedge clk);
        ex_mispredict = 0;
        for (int k = 1; k < 6; k++) begin
            @(posedge clk); #1;
            expect_v(K_FLUSH, 32'd0, "R11");
            expect_v(K_BUSY, 32'd1, "R11");
            ->sample_ev;
        end
        @(posedge clk); #1;
        expect_v(K_BUSY, 32'd0, "R11");
        ->sample_ev;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        lookup(32'h100, 0, 32'h104, "R1");
        #1;
        expect_v(K_FLUSH, 0, "R1"); expect_v(K_BUSY, 0, "R1"); ->sample_ev;
        decode(32'h200, 0, 0, 0, 0, 1, 0, 0, 0, "R1");

        // R2: taken miss allocates, zero-bubble target
        resolve(32'h1000, 1, 32'h2000);
        lookup(32'h1000, 1, 32'h2000, "R2");
        #1; expect_v(K_TAKEN, 1, "R2"); ->sample_ev;

        // R3: not-taken miss allocates nothing
        resolve(32'h1100, 0, 32'h5000);
        lookup(32'h1100, 0, 32'h1104, "R3");

        // R4: saturation at 3
        resolve(32'h1000, 1, 32'h2000);
        resolve(32'h1000, 1, 32'h2000);
        resolve(32'h1000, 0, 32'h2000);
        lookup(32'h1000, 1, 32'h2000, "R4");
        resolve(32'h1000, 0, 32'h2000);
        lookup(32'h1000, 1, 32'h1004, "R4");
        #1; expect_v(K_TAKEN, 0, "R4"); ->sample_ev;
        // R4: saturation at 0
        resolve(32'h1000, 0, 32'h2000);
        resolve(32'h1000, 0, 32'h2000);
        resolve(32'h1000, 1, 32'h2000);
        lookup(32'h1000, 1, 32'h1004, "R4");
        resolve(32'h1000, 1, 32'h2000);
        lookup(32'h1000, 1, 32'h2000, "R4");

        // R5: index/tag aliasing
        lookup(32'h1200, 0, 32'h1204, "R5");
        resolve(32'h1200, 1, 32'h3000);
        lookup(32'h1200, 1, 32'h3000, "R5");
        lookup(32'h1202, 1, 32'h3000, "R5");
        lookup(32'h1000, 0, 32'h1004, "R5");

        // R6: static rule
        decode(32'h500, 32'hFFFF_FFC0, 1, 1, 0, 0, 0, 1, 32'h4C0, "R6");
        decode(32'h500, 32'h40, 1, 1, 0, 0, 0, 0, 0, "R6");
        decode(32'h500, 32'h80, 1, 0, 0, 0, 0, 1, 32'h580, "R6");

        // R7: table hit suppresses decode redirect
        decode(32'h500, 32'hFFFF_FFC0, 1, 1, 0, 0, 1, 0, 0, "R7");
        decode(32'h500, 32'h80, 1, 0, 0, 0, 1, 0, 0, "R7");

        // R8: call/return LIFO
        decode(32'h600, 32'h100, 1, 0, 1, 0, 0, 1, 32'h700, "R8");
        decode(32'h800, 32'h100, 1, 0, 1, 0, 0, 1, 32'h900, "R8");
        decode(32'h950, 0, 0, 0, 0, 1, 0, 1, 32'h804, "R8");
        decode(32'h960, 0, 0, 0, 0, 1, 0, 1, 32'h604, "R8");
        decode(32'h970, 0, 0, 0, 0, 1, 0, 0, 0, "R10");

        // R9: conditional return ignored
        decode(32'h900, 32'h10, 1, 0, 1, 0, 0, 1, 32'h910, "R9");
        decode(32'h980, 0, 0, 1, 0, 1, 0, 0, 0, "R9");
        decode(32'h990, 0, 0, 0, 0, 1, 0, 1, 32'h904, "R9");

        // R10: overflow overwrites oldest
        decode(32'hA00, 32'h4, 1, 0, 1, 0, 0, 1, 32'hA04, "R10");
        decode(32'hB00, 32'h4, 1, 0, 1, 0, 0, 1, 32'hB04, "R10");
        decode(32'hC00, 32'h4, 1, 0, 1, 0, 0, 1, 32'hC04, "R10");
        decode(32'hD00, 32'h4, 1, 0, 1, 0, 0, 1, 32'hD04, "R10");
        decode(32'hE00, 0, 0, 0, 0, 1, 0, 1, 32'hD04, "R10");
        decode(32'hE10, 0, 0, 0, 0, 1, 0, 1, 32'hC04, "R10");
        decode(32'hE20, 0, 0, 0, 0, 1, 0, 1, 32'hB04, "R10");
        decode(32'hE30, 0, 0, 0, 0, 1, 0, 0, 0, "R10");

        // R11: mispredict penalty
        mispredict(32'h6000, 1, 32'h7000, 32'h7000);
        mispredict(32'h7100, 0, 32'h9000, 32'h7104);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule